// File: doc/BRIEF.md
# Interrupt Mask/Status Controller

This block gathers up to 32 interrupt lines and turns them into one interrupt request for a processor core. Software controls it through two registers. The enable register opens or closes each line. The pending register records which lines want service. Reads are combinational. Writes take effect on the next clock edge.

A two-bit mode input selects one of three acknowledge conventions:

- **Level mode:** the pending bits simply follow the enabled inputs.
- **Edge mode:** a rising edge on a line sets its pending bit, and software clears the bit by writing 1 to it.
- **Sticky mode:** an active input level is caught in a sticky pending bit, and software clears it by writing 0 to that bit. Software does this with a read-modify-write.

Besides the request, the block reports the number of the lowest pending line so that software can service lines from the bottom up.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is high, and after it, until software writes, the enable and pending registers read as zero and the request is low.
- R2: Address 0 selects the enable register and address 1 selects the pending register. A write with `wr_en_i` high updates the selected register at the clock edge. Read data shows the selected register in the same cycle.
- R3: The request is high exactly when some pending bit is 1 and its enable bit is 1. When the enable register is all zero, no input activity raises the request.
- R4: In level mode (mode 0; mode 3 also acts as level), each pending bit equals the input AND the enable bit as of the previous clock edge. Writes to the pending register have no effect.
- R5: In edge mode (mode 1), a 0-to-1 change on an input between two clock edges sets its pending bit. The bit stays set after the input falls. An input that stays high does not set the bit again.
- R6: In edge mode, writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: In sticky mode (mode 2), an input that is high at a clock edge sets its pending bit. The bit stays set after the input goes low.
- R8: In sticky mode, writing 0 to a pending bit clears it. Writing 1 leaves it unchanged.
- R9: When a set event (an edge, or a high level in sticky mode) and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: `pend_valid_o` is high when any enabled pending bit exists. `pend_idx_o` gives the lowest-numbered such line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Acknowledge convention: 0 level, 1 edge, 2 sticky, 3 level |
| irq_lines_i | input | 32 | Interrupt input lines, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 enable, 1 pending |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the selected register |
| irq_req_o | output | 1 | Interrupt request to the core |
| pend_valid_o | output | 1 | Some enabled line is pending |
| pend_idx_o | output | 5 | Lowest-numbered enabled pending line |

## Verification
The bound checker checks the following on every cycle:

- reset clears the registers;
- the request never rises while every line is disabled;
- in edge mode no pending bit appears without its input having been high;
- in sticky mode captured bits persist without a write;
- in sticky mode a high input always wins over a clear;
- the reported index always points at an enabled, pending line.

Only the bench scenarios show the following:

- the write-1 and write-0 acknowledge conventions of each mode;
- that a steady high input in edge mode does not re-arm;
- that pending writes are ignored in level mode;
- that the lowest line is chosen across mixed enable patterns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_LINES = 32;
    localparam int IDX_W     = $clog2(NUM_LINES);

    typedef enum logic [1:0] {
        ACK_LEVEL  = 2'd0,
        ACK_EDGE   = 2'd1,
        ACK_STICKY = 2'd2
    } ack_mode_e;

    typedef enum logic {
        SEL_MASK   = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic mask_we;
        logic stat_we;
    } wr_strobe_t;

    // Encoding 3 is not defined and falls back to level behaviour.
    function automatic ack_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'd1:    return ACK_EDGE;
            2'd2:    return ACK_STICKY;
            default: return ACK_LEVEL;
        endcase
    endfunction

    function automatic wr_strobe_t decode_write(input logic we, input logic sel);
        wr_strobe_t s;
        s.mask_we = we && (reg_sel_e'(sel) == SEL_MASK);
        s.stat_we = we && (reg_sel_e'(sel) == SEL_STATUS);
        return s;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int N = irqc_pkg::NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise_o[g] = lines_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
#(
    parameter int N = irqc_pkg::NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  ack_mode_e    mode_i,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] mask_i,
    input  logic         stat_we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] status_o
);

    logic [N-1:0] status_q;
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;
    logic [N-1:0] status_d;

    always_comb begin
        set_v    = '0;
        clr_v    = '0;
        status_d = status_q;
        case (mode_i)
            ACK_EDGE: begin
                set_v    = rise_i;
                clr_v    = stat_we_i ? wdata_i : '0;
                status_d = (status_q & ~clr_v) | set_v;
            end
            ACK_STICKY: begin
                set_v    = lines_i;
                clr_v    = stat_we_i ? ~wdata_i : '0;
                status_d = (status_q & ~clr_v) | set_v;
            end
            default: begin
                status_d = lines_i & mask_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    assign status_o = status_q;

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N     = irqc_pkg::NUM_LINES,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign valid_o = |req_i;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N     = irqc_pkg::NUM_LINES,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [N-1:0]     irq_lines_i,
    input  logic             wr_en_i,
    input  logic             addr_i,
    input  logic [N-1:0]     wr_data_i,
    output logic [N-1:0]     rd_data_o,
    output logic             irq_req_o,
    output logic             pend_valid_o,
    output logic [IDX_W-1:0] pend_idx_o
);

    ack_mode_e    mode;
    wr_strobe_t   strobe;
    logic [N-1:0] mask_q;
    logic [N-1:0] status_q;
    logic [N-1:0] rise;
    logic [N-1:0] pending;

    assign mode   = decode_mode(mode_i);
    assign strobe = decode_write(wr_en_i, addr_i);

    always_ff @(posedge clk) begin
        if (rst)                 mask_q <= '0;
        else if (strobe.mask_we) mask_q <= wr_data_i;
    end

    irqc_capture #(.N(N)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .lines_i (irq_lines_i),
        .rise_o  (rise)
    );

    irqc_status #(.N(N)) u_status (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .lines_i   (irq_lines_i),
        .rise_i    (rise),
        .mask_i    (mask_q),
        .stat_we_i (strobe.stat_we),
        .wdata_i   (wr_data_i),
        .status_o  (status_q)
    );

    assign pending = status_q & mask_q;

    irqc_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
        .req_i   (pending),
        .valid_o (pend_valid_o),
        .idx_o   (pend_idx_o)
    );

    assign irq_req_o = pend_valid_o;
    assign rd_data_o = (reg_sel_e'(addr_i) == SEL_STATUS) ? status_q : mask_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int N     = irqc_pkg::NUM_LINES,
    parameter int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_i,
    input logic [N-1:0]     irq_lines_i,
    input logic             wr_en_i,
    input logic             addr_i,
    input logic [IDX_W-1:0] pend_idx_o,
    input logic             pend_valid_o,
    input logic             irq_req_o,
    input logic [N-1:0]     mask_q,
    input logic [N-1:0]     status_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && status_q == '0));

    // R3
    mask_block_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_req_o);

    // R5
    edge_source_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == 2'd1 && !$past(rst)) |->
        ((status_q & ~$past(status_q) & ~$past(irq_lines_i)) == '0));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == 2'd2 && !$past(rst) && !($past(wr_en_i) && $past(addr_i))) |->
        ((status_q & $past(status_q)) == $past(status_q)));

    // R9
    sticky_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == 2'd2 && !$past(rst)) |->
        ((status_q & $past(irq_lines_i)) == $past(irq_lines_i)));

    // R10
    index_points_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid_o |-> (status_q[pend_idx_o] && mask_q[pend_idx_o]));

    // R3
    req_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> ((status_q & mask_q) != '0));

endmodule

bind irq_ctrl irqc_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .irq_lines_i  (irq_lines_i),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .pend_idx_o   (pend_idx_o),
    .pend_valid_o (pend_valid_o),
    .irq_req_o    (irq_req_o),
    .mask_q       (mask_q),
    .status_q     (status_q)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'd0;
    logic [31:0] irq_lines_i = '0;
    logic        wr_en_i = 1'b0;
    logic        addr_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_req_o;
    logic        pend_valid_o;
    logic [4:0]  pend_idx_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_mask = '0;
    logic [31:0] m_stat = '0;
    logic [31:0] m_prev = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode_i),
        .irq_lines_i  (irq_lines_i),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wr_data_i    (wr_data_i),
        .rd_data_o    (rd_data_o),
        .irq_req_o    (irq_req_o),
        .pend_valid_o (pend_valid_o),
        .pend_idx_o   (pend_idx_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [31:0] pend;
        logic [4:0]  idx;
        pend = m_stat & m_mask;
        idx  = '0;
        for (int i = 31; i >= 0; i--) if (pend[i]) idx = 5'(i);
        check("R3 request", {31'd0, irq_req_o}, {31'd0, |pend});
        check("R10 valid", {31'd0, pend_valid_o}, {31'd0, |pend});
        if (|pend) check("R10 index", {27'd0, pend_idx_o}, {27'd0, idx});
        check(tag, rd_data_o, addr_i ? m_stat : m_mask);
    endtask

    // One clock: model the next state from the requirements, then compare.
    task automatic step(input string tag);
        logic [31:0] nm, ns, clr;
        logic        sw;
        nm = (wr_en_i && !addr_i) ? wr_data_i : m_mask;
        sw = wr_en_i && addr_i;
        case (mode_i)
            2'd1: begin
                clr = sw ? wr_data_i : '0;
                ns  = (m_stat & ~clr) | (irq_lines_i & ~m_prev);
            end
            2'd2: begin
                clr = sw ? ~wr_data_i : '0;
                ns  = (m_stat & ~clr) | irq_lines_i;
            end
            default: ns = irq_lines_i & m_mask;
        endcase
        @(posedge clk);
        m_mask = nm;
        m_stat = ns;
        m_prev = irq_lines_i;
        #1;
        check_outputs(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en_i = 1'b0; irq_lines_i = '0;
        @(posedge clk); @(posedge clk); #1;
        m_mask = '0; m_stat = '0; m_prev = '0;
        addr_i = 1'b0; #1; check("R1 enable", rd_data_o, 32'd0);
        addr_i = 1'b1; #1; check("R1 pending", rd_data_o, 32'd0);
        check("R1 request", {31'd0, irq_req_o}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d, input string tag);
        wr_en_i = 1'b1; addr_i = sel; wr_data_i = d;
        step(tag);
        wr_en_i = 1'b0; addr_i = 1'b1;
    endtask

    task automatic run_mode(input logic [1:0] m);
        string set_tag, clr_tag;
        set_tag = (m == 2'd0) ? "R4" : (m == 2'd1) ? "R5" : "R7";
        clr_tag = (m == 2'd0) ? "R4" : (m == 2'd1) ? "R6" : "R8";
        do_reset();
        mode_i = m;
        write_reg(1'b0, 32'hFFFF_FFFF, "R2 enable write");
        addr_i = 1'b0; #1; check("R2 enable read", rd_data_o, m_mask);
        addr_i = 1'b1;
        for (int i = 0; i < 32; i++) begin
            irq_lines_i = 32'd1 << i; step(set_tag);
            step(set_tag);
            irq_lines_i = '0;         step(set_tag);
            write_reg(1'b1, (m == 2'd2) ? 32'hFFFF_FFFF : 32'd0, clr_tag);
            write_reg(1'b1, (m == 2'd2) ? ~(32'd1 << i) : (32'd1 << i), clr_tag);
            step(clr_tag);
        end
        // Set event collides with a clearing write to the same bit
        irq_lines_i = 32'h0000_0008;
        write_reg(1'b1, (m == 2'd2) ? 32'hFFFF_FFF7 : 32'h0000_0008, "R9");
        irq_lines_i = '0; step("R9");
        // Lowest enabled pending line across mixed enable patterns
        for (int a = 0; a < 32; a += 3) begin
            write_reg(1'b1, (m == 2'd2) ? 32'd0 : 32'hFFFF_FFFF, "R10 clear");
            write_reg(1'b0, (a % 2 == 1) ? ~(32'd1 << a) : 32'hFFFF_FFFF, "R2");
            irq_lines_i = (32'd1 << a) | (32'd1 << (31 - a)) | 32'h8000_0000;
            step("R10"); step("R10");
            irq_lines_i = '0; step("R10");
        end
        // Everything disabled: no request whatever the inputs do
        write_reg(1'b0, 32'd0, "R3 disable");
        for (int k = 0; k < 8; k++) begin
            irq_lines_i = (k % 2 == 0) ? 32'hA5A5_0000 >> k : 32'h5A5A_FFFF << k;
            step("R3");
        end
        irq_lines_i = '0; step("R3");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD / 4);
        run_mode(2'd0);
        run_mode(2'd1);
        run_mode(2'd2);
        run_mode(2'd3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule